// File: doc/BRIEF.md
# SPI Chip-Select Output Controller

This block owns the chip-select pins of an SPI master. Up to six lines are supported, and a reduced build can use three. Each line can be handed to chip-select duty, and its output can be inverted so that active-high slave devices are served. Software moves each line between its active and inactive level by writing a forced-output register. That register has one group of bits that drive lines inactive and a second group that drive them active. The block holds the per-line state and applies the enable and inversion to produce the pin levels.

Two write strobes come in from an external register decoder. One strobe writes the control register and the other writes the forced-output register, and both carry the same 16-bit data word. The block returns both registers continuously for readback. Software activates a line only after the serial engine has entered run mode, and it releases the line before the engine goes back to config mode. The sequencing is done by software, and this block only holds and applies the levels. Pad multiplexing is handled outside the block.

Top module: `cs_out_ctrl`

## Requirements
- R1: After reset every pin `cs_o` is 1, the control readback is 0, and the forced-output readback has bits [NUM_CS-1:0] at 1 (all lines inactive).
- R2: A control write stores data bit [8+n] as the chip-select enable of line n and data bit [n] as its inversion enable. Both read back in the same positions, and every other readback bit is 0.
- R3: A line whose enable is 0 drives its pin at 1, whatever its forced state and inversion bit.
- R4: A forced-output write with bit [8+n]=1 and bit [n]=0 sets the state of line n to 1 (inactive). A write with bit [n]=1 and bit [8+n]=0 sets it to 0 (active).
- R5: A forced-output write with both bit [8+n] and bit [n] at 1 leaves the state of line n unchanged.
- R6: A line whose two forced-output bits are both 0 in a write keeps its state. No state or control bit changes in a cycle without the matching write strobe.
- R7: An enabled line drives its pin at state XOR inversion bit.
- R8: Writing 0xFF00 to the forced-output register makes every state 1. Writing 0 to the control register returns every pin to 1.
- R9: The forced-output readback shows the state of line n in bit [n], and its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| frc_we_i | input | 1 | Forced-output register write strobe |
| wdata_i | input | 16 | Write data for either register |
| ctl_rdata_o | output | 16 | Control register readback |
| frc_rdata_o | output | 16 | Forced-output state readback |
| cs_o | output | NUM_CS | Chip-select pin levels |

## Verification
The checker enforces on every cycle several properties of the outputs. A disabled pin must be high, and an enabled pin must equal its state XOR inversion. It also checks that both register images hold when there is no strobe, and that set-only, clear-only and set-plus-clear writes move the state correctly. The reset values, the readback bit placement, and the effect of the 0xFF00 and zero writes can only be shown by the bench's scenarios. The same holds for full agreement with an arithmetic model over every per-line combination of enable, inversion and write action.

// File: rtl/cs_out_pkg.sv
package cs_out_pkg;
  localparam int REG_W  = 16;
  localparam int HI_OFS = 8;   // set / enable field offset
  localparam int MAX_CS = 8;
endpackage

// File: rtl/cs_ctl_reg.sv
module cs_ctl_reg #(
  parameter int NUM_CS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NUM_CS-1:0] en_wd_i,
  input  logic [NUM_CS-1:0] inv_wd_i,
  output logic [NUM_CS-1:0] en_o,
  output logic [NUM_CS-1:0] inv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      inv_o <= '0;
    end else if (we_i) begin
      en_o  <= en_wd_i;
      inv_o <= inv_wd_i;
    end
  end
endmodule

// File: rtl/cs_line.sv
module cs_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic inv_i,
  output logic state_o,
  output logic pin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      state_o <= 1'b1;
    else if (we_i && set_i && !clr_i) state_o <= 1'b1;
    else if (we_i && clr_i && !set_i) state_o <= 1'b0;
  end

  // unused line parks high
  assign pin_o = en_i ? (state_o ^ inv_i) : 1'b1;
endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
  import cs_out_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              frc_we_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       ctl_rdata_o,
  output logic [15:0]       frc_rdata_o,
  output logic [NUM_CS-1:0] cs_o
);
  localparam int LO_W = HI_OFS;

  logic [NUM_CS-1:0] en_q, inv_q, state_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  cs_ctl_reg #(.NUM_CS(NUM_CS)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .en_wd_i  (wdata_i[HI_OFS +: NUM_CS]),
    .inv_wd_i (wdata_i[0 +: NUM_CS]),
    .en_o     (en_q),
    .inv_o    (inv_q)
  );

  for (genvar n = 0; n < NUM_CS; n++) begin : g_line
    cs_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (frc_we_i),
      .set_i   (wdata_i[HI_OFS + n]),
      .clr_i   (wdata_i[n]),
      .en_i    (en_q[n]),
      .inv_i   (inv_q[n]),
      .state_o (state_q[n]),
      .pin_o   (cs_o[n])
    );
  end

  always_comb begin
    ctl_rdata_o = '0;
    ctl_rdata_o[HI_OFS +: NUM_CS] = en_q;
    ctl_rdata_o[0 +: NUM_CS]      = inv_q;
    frc_rdata_o = '0;
    frc_rdata_o[0 +: NUM_CS]      = state_q;
  end

  initial begin
    if (NUM_CS < 1 || NUM_CS > LO_W) $error("NUM_CS out of range");
  end
endmodule

// File: rtl/cs_out_chk.sv
module cs_out_chk
  import cs_out_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_we_i,
  input logic              frc_we_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       ctl_rdata_o,
  input logic [15:0]       frc_rdata_o,
  input logic [NUM_CS-1:0] cs_o
);
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(ctl_rdata_o)); // R6
  AST_FRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frc_we_i |=> $stable(frc_rdata_o)); // R6

  for (genvar n = 0; n < NUM_CS; n++) begin : g_chk
    AST_DIS_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl_rdata_o[HI_OFS+n] |-> cs_o[n]); // R3
    AST_PIN_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_rdata_o[HI_OFS+n] |-> (cs_o[n] == (frc_rdata_o[n] ^ ctl_rdata_o[n]))); // R7
    AST_SET_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frc_we_i && wdata_i[HI_OFS+n] && !wdata_i[n]) |=> frc_rdata_o[n]); // R4
    AST_CLR_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frc_we_i && !wdata_i[HI_OFS+n] && wdata_i[n]) |=> !frc_rdata_o[n]); // R4
    AST_BOTH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frc_we_i && wdata_i[HI_OFS+n] && wdata_i[n]) |=> $stable(frc_rdata_o[n])); // R5
  end
endmodule

bind cs_out_ctrl cs_out_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .frc_we_i    (frc_we_i),
  .wdata_i     (wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .frc_rdata_o (frc_rdata_o),
  .cs_o        (cs_o)
);

// File: tb/tb_cs_out_ctrl.sv
module tb_cs_out_ctrl;
  localparam int N = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ctl_we_i = 1'b0;
  logic          frc_we_i = 1'b0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   ctl_rdata_o, frc_rdata_o;
  logic [N-1:0]  cs_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] m_en, m_inv, m_st;
  logic [31:0]  lcg = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  cs_out_ctrl #(.NUM_CS(N)) dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pins();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = m_en[i] ? (m_st[i] ^ m_inv[i]) : 1'b1;
    return p;
  endfunction

  task automatic check_all(input string req);
    chk(req, {10'd0, cs_o}, {10'd0, exp_pins()});
    chk(req, ctl_rdata_o, {2'b0, m_en, 2'b0, m_inv});
    chk(req, frc_rdata_o, {10'd0, m_st});
  endtask

  // drive on falling edge, sample at next falling edge
  task automatic wr(input logic c, input logic f, input logic [15:0] d);
    @(negedge clk_i);
    ctl_we_i = c; frc_we_i = f; wdata_i = d;
    @(negedge clk_i);
    ctl_we_i = 1'b0; frc_we_i = 1'b0;
    if (c) begin m_en = d[13:8]; m_inv = d[5:0]; end
    if (f)
      for (int i = 0; i < N; i++) begin
        if (d[8+i] && !d[i]) m_st[i] = 1'b1;
        if (d[i] && !d[8+i]) m_st[i] = 1'b0;
      end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_en = '0; m_inv = '0; m_st = '1;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 reset");

    // idle cycles with data but no strobe: R6
    @(negedge clk_i); wdata_i = 16'hFFFF;
    @(negedge clk_i);
    check_all("R6 no strobe");

    // R4 clear all active while disabled: R3 pins stay high
    wr(1'b0, 1'b1, 16'h003F);
    check_all("R3 disabled pins high");
    wr(1'b1, 1'b0, 16'hFFFF);
    check_all("R2 ctl upper bits dropped");
    check_all("R7 inverted active");
    wr(1'b0, 1'b1, 16'hFF00);
    check_all("R8 release all");
    wr(1'b1, 1'b0, 16'h0000);
    check_all("R8 disable all");
    wr(1'b0, 1'b1, 16'h0000);
    check_all("R6 zero frc write");

    // per-line exhaustive: enable/inv x set/clr action, two start states
    for (int n = 0; n < N; n++)
      for (int cfg = 0; cfg < 4; cfg++)
        for (int pre = 0; pre < 2; pre++)
          for (int act = 0; act < 4; act++) begin
            logic [15:0] d;
            d = '0; d[8+n] = cfg[1]; d[n] = cfg[0];
            wr(1'b1, 1'b0, d);
            d = '0; d[8+n] = pre[0]; d[n] = !pre[0];
            wr(1'b0, 1'b1, d);
            d = '0; d[8+n] = act[1]; d[n] = act[0];
            wr(1'b0, 1'b1, d);
            if (act == 3)      check_all("R5 set and clear");
            else if (act == 2) check_all("R4 set inactive");
            else if (act == 1) check_all("R4 clear active");
            else               check_all("R6 no bits");
            chk("R9 state bit", {15'd0, frc_rdata_o[n]},
                {15'd0, (act == 2) ? 1'b1 : (act == 1) ? 1'b0 : pre[0]});
          end

    // pseudo-random mixed writes, both strobes at once allowed
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wr(lcg[30], lcg[29], lcg[15:0]);
      check_all("R7 random mix");
    end

    wr(1'b1, 1'b1, 16'hFF00);
    check_all("R8 combined release");

    // reset mid-run returns defaults
    wr(1'b1, 1'b1, 16'h2A15);
    rst_ni = 1'b0; #10 rst_ni = 1'b1;
    m_en = '0; m_inv = '0; m_st = '1;
    @(negedge clk_i);
    check_all("R1 second reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule